// File: doc/BRIEF.md
# Endpoint Bank Ownership Controller

This block keeps the handshake state of a single USB device endpoint whose packet memory is split into one or more banks. Each bank holds one packet and is owned either by the USB side or by the CPU side. The block takes event strobes from the USB packet engine: SETUP packet stored, OUT packet stored, IN bank transmitted, and isochronous underflow. It also takes write-one-to-clear acknowledge strobes and a bank-release strobe from the CPU side. From these it keeps the status flags, a CPU ownership flag, one bank pointer for each side, a request that tells the USB engine a bank is loaded for sending, and the endpoint interrupt.

The endpoint configuration is static while the block runs. It is changed only while reset is asserted. The configuration gives the transfer type, the direction and the number of banks. A control endpoint uses one bank, and each acknowledge both clears the flag and moves the bank. On isochronous, bulk and interrupt endpoints, release has two steps. Software first acknowledges the flag, which leaves the banks as they are. Software then releases the bank, and the CPU pointer moves on through the ring of banks.

Top module: `ep_bank_ctrl`

## Requirements
- R1: While reset is asserted and on the first cycle after it, every bank is empty, both pointers are 0, and `st_stp`, `st_rxout` and `st_seq_err` are 0. `st_txin` is 1 on control endpoints and on non-control IN endpoints, and 0 otherwise. `st_own` is 1 only on non-control IN endpoints.
- R2: The type code `cfg_type` is 0 for control, 1 for isochronous, 2 for bulk and 3 for interrupt. On a control endpoint with its bank empty, `usb_setup` sets `st_stp` and clears `st_txin` on the next cycle. `cpu_ack_stp` with `st_stp` set clears `st_stp`, empties the bank and sets `st_txin` again.
- R3: On a control endpoint with its bank empty, `usb_out_stored` sets `st_rxout` and clears `st_txin`. `cpu_ack_rxout` clears `st_rxout`, empties the bank and sets `st_txin`. A SETUP or OUT strobe that arrives while the bank is full is dropped.
- R4: On a control endpoint, `cpu_ack_txin` with `st_txin` set clears `st_txin` and loads the bank for sending, which raises `usb_send_req`. `usb_in_sent` then empties the bank, drops `usb_send_req` and sets `st_txin`.
- R5: On a non-control OUT endpoint, `usb_out_stored` fills the bank at `usb_bank` only if that bank is empty, and then advances `usb_bank`. When that bank is the CPU bank, `st_rxout` and `st_own` rise together. A strobe that arrives when all banks are full leaves `usb_bank` unchanged.
- R6: On non-control endpoints, `cpu_ack_rxout` or `cpu_ack_txin` clears only the flag. `st_own`, both pointers and the bank states stay as they were.
- R7: On a non-control endpoint, `cpu_release` with `st_own` set and the flag cleared gives the CPU bank back and advances `cpu_bank` modulo the bank count. The flag and `st_own` are then reloaded from the state of the next bank. The bank count is `cfg_banks`, with 0 taken as 1 and values above MAX_BANKS taken as MAX_BANKS.
- R8: On a non-control IN endpoint, a released bank is loaded for sending. `usb_send_req` is 1 while the bank at `usb_bank` is loaded. `usb_in_sent` frees that bank and advances `usb_bank`, and it is ignored when no bank is loaded. When the freed bank is the CPU bank, `st_txin` and `st_own` rise together.
- R9: A `cpu_release` that arrives while `st_own` and the flag of the endpoint's direction are both set is ignored and sets `st_seq_err`. That bit stays set until reset.
- R10: On isochronous endpoints, `usb_underflow` sets `st_stp` and `cpu_ack_stp` clears it. On bulk and interrupt endpoints, `st_stp` stays 0.
- R11: `st_rxout` is always 0 on non-control IN endpoints, and `st_txin` is always 0 on non-control OUT endpoints. `st_own` is always 0 on control endpoints, where `cpu_release` has no effect.
- R12: `ep_irq` is the OR of (`st_stp` AND `en_stp`), (`st_rxout` AND `en_rxout`) and (`st_txin` AND `en_txin`). It follows the flags in the same cycle and the enables combinationally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_type | input | 2 | Transfer type: 0 control, 1 isochronous, 2 bulk, 3 interrupt |
| cfg_dir_in | input | 1 | 1 = IN endpoint, 0 = OUT endpoint (ignored for control) |
| cfg_banks | input | $clog2(MAX_BANKS+1) | Bank count (clamped to 1..MAX_BANKS) |
| usb_setup | input | 1 | USB side stored a SETUP packet |
| usb_out_stored | input | 1 | USB side stored an OUT packet |
| usb_in_sent | input | 1 | USB side finished sending the loaded bank |
| usb_underflow | input | 1 | Isochronous underflow event |
| cpu_ack_stp | input | 1 | Clear strobe for the SETUP/underflow flag |
| cpu_ack_rxout | input | 1 | Clear strobe for the OUT-received flag |
| cpu_ack_txin | input | 1 | Clear strobe for the IN-ready flag |
| cpu_release | input | 1 | Clear strobe for the CPU ownership flag (bank release) |
| en_stp | input | 1 | Interrupt enable for the SETUP/underflow flag |
| en_rxout | input | 1 | Interrupt enable for the OUT-received flag |
| en_txin | input | 1 | Interrupt enable for the IN-ready flag |
| st_stp | output | 1 | SETUP flag (control) or underflow flag (isochronous) |
| st_rxout | output | 1 | OUT-received flag |
| st_txin | output | 1 | IN-ready flag |
| st_own | output | 1 | CPU owns the current bank |
| st_seq_err | output | 1 | Sticky: release attempted while the flag was still set |
| usb_bank | output | $clog2(MAX_BANKS) | USB-side bank pointer |
| cpu_bank | output | $clog2(MAX_BANKS) | CPU-side bank pointer |
| usb_send_req | output | 1 | The bank at `usb_bank` is loaded and waiting to be sent |
| ep_irq | output | 1 | Endpoint interrupt |

## Verification
Every strobe is captured at one rising edge. The flags, `st_own`, both pointers, `st_seq_err` and `usb_send_req` all show its effect right after that edge, so their latency is one cycle. `ep_irq` adds no register to the flags and follows a change of the enable inputs with no clock at all. The bench drives each strobe for one cycle starting at a falling edge and removes it at the next falling edge. It samples there, half a cycle after the capturing edge and before the next one. For the interrupt sweep it changes only the enables and samples a moment later with no edge in between. The sweep runs every non-control type with both directions and every bank count setting, including the clamped value 0, and then runs a control endpoint through its SETUP, OUT and IN handshakes.

// File: rtl/ep_bank_pkg.sv
package ep_bank_pkg;

    typedef enum logic [1:0] {
        EP_CTRL = 2'd0,
        EP_ISO  = 2'd1,
        EP_BULK = 2'd2,
        EP_INTR = 2'd3
    } ep_kind_e;

    typedef struct packed {
        logic stp;
        logic rxout;
        logic txin;
        logic own;
        logic seq_err;
    } ep_flags_t;

endpackage

// File: rtl/ep_bank_ring.sv
module ep_bank_ring #(
    parameter int MAX_BANKS = 3,
    localparam int PW = (MAX_BANKS > 1) ? $clog2(MAX_BANKS) : 1,
    localparam int BW = $clog2(MAX_BANKS + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [BW-1:0]        nbanks,
    input  logic                 usb_op,
    input  logic                 usb_val,
    input  logic                 usb_adv,
    input  logic                 cpu_op,
    input  logic                 cpu_val,
    input  logic                 cpu_adv,
    output logic [MAX_BANKS-1:0] full_q,
    output logic [PW-1:0]        usb_ptr_q,
    output logic [PW-1:0]        cpu_ptr_q,
    output logic [MAX_BANKS-1:0] full_d,
    output logic [PW-1:0]        cpu_ptr_d
);

    typedef struct packed {
        logic [MAX_BANKS-1:0] full;
        logic [PW-1:0]        uptr;
        logic [PW-1:0]        cptr;
    } ring_t;

    ring_t r_d, r_q;

    function automatic logic [PW-1:0] step(input logic [PW-1:0] p, input logic [BW-1:0] n);
        if (int'(p) + 1 >= int'(n)) return '0;
        return p + 1'b1;
    endfunction

    always_comb begin
        r_d = r_q;
        for (int i = 0; i < MAX_BANKS; i++) begin
            if (usb_op && r_q.uptr == PW'(i))
                r_d.full[i] = usb_val;
            else if (cpu_op && r_q.cptr == PW'(i))
                r_d.full[i] = cpu_val;
        end
        if (usb_adv) r_d.uptr = step(r_q.uptr, nbanks);
        if (cpu_adv) r_d.cptr = step(r_q.cptr, nbanks);
    end

    always_ff @(posedge clk) begin
        if (rst) r_q <= '0;
        else     r_q <= r_d;
    end

    assign full_q    = r_q.full;
    assign usb_ptr_q = r_q.uptr;
    assign cpu_ptr_q = r_q.cptr;
    assign full_d    = r_d.full;
    assign cpu_ptr_d = r_d.cptr;

    AST_USB_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(usb_ptr_q) < int'(nbanks)) else $error("usb pointer out of range"); // R7
    AST_CPU_PTR_RANGE: assert property (@(posedge clk) disable iff (rst)
        int'(cpu_ptr_q) < int'(nbanks)) else $error("cpu pointer out of range"); // R7
    AST_NO_OVERWRITE: assert property (@(posedge clk) disable iff (rst)
        (usb_op && usb_val) |-> !full_q[usb_ptr_q]) else $error("filled a full bank"); // R5

endmodule

// File: rtl/ep_irq_mask.sv
module ep_irq_mask #(
    parameter int NSRC = 3
) (
    input  logic [NSRC-1:0] flags,
    input  logic [NSRC-1:0] enables,
    output logic            irq
);

    logic [NSRC-1:0] hit;

    for (genvar g = 0; g < NSRC; g++) begin : g_src
        assign hit[g] = flags[g] & enables[g];
    end

    assign irq = |hit;

endmodule

// File: rtl/ep_bank_ctrl.sv
module ep_bank_ctrl
    import ep_bank_pkg::*;
#(
    parameter int MAX_BANKS = 3,
    localparam int PW = (MAX_BANKS > 1) ? $clog2(MAX_BANKS) : 1,
    localparam int BW = $clog2(MAX_BANKS + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic [1:0]    cfg_type,
    input  logic          cfg_dir_in,
    input  logic [BW-1:0] cfg_banks,
    input  logic          usb_setup,
    input  logic          usb_out_stored,
    input  logic          usb_in_sent,
    input  logic          usb_underflow,
    input  logic          cpu_ack_stp,
    input  logic          cpu_ack_rxout,
    input  logic          cpu_ack_txin,
    input  logic          cpu_release,
    input  logic          en_stp,
    input  logic          en_rxout,
    input  logic          en_txin,
    output logic          st_stp,
    output logic          st_rxout,
    output logic          st_txin,
    output logic          st_own,
    output logic          st_seq_err,
    output logic [PW-1:0] usb_bank,
    output logic [PW-1:0] cpu_bank,
    output logic          usb_send_req,
    output logic          ep_irq
);

    ep_kind_e  kind;
    logic      is_ctrl, is_iso;
    logic [BW-1:0] nb_eff;

    ep_flags_t f_d, f_q;

    logic [MAX_BANKS-1:0] full_q, full_d;
    logic [PW-1:0]        uptr_q, cptr_q, cptr_d;

    // event decode
    logic usb_op, usb_val, usb_adv, cpu_op, cpu_val, cpu_adv;
    logic fill_setup, fill_out, fill, ctl_sent, ack_s, ack_r, load;
    logic accept, refuse, flag_cur_q, ack_cur;

    assign kind    = ep_kind_e'(cfg_type);
    assign is_ctrl = (kind == EP_CTRL);
    assign is_iso  = (kind == EP_ISO);

    always_comb begin
        if (is_ctrl || cfg_banks == '0)
            nb_eff = BW'(1);
        else if (int'(cfg_banks) > MAX_BANKS)
            nb_eff = BW'(MAX_BANKS);
        else
            nb_eff = cfg_banks;
    end

    always_comb begin
        fill_setup = 1'b0; fill_out = 1'b0; fill = 1'b0; ctl_sent = 1'b0;
        ack_s = 1'b0; ack_r = 1'b0; load = 1'b0;
        accept = 1'b0; refuse = 1'b0; ack_cur = 1'b0;
        usb_op = 1'b0; usb_val = 1'b0; usb_adv = 1'b0;
        cpu_op = 1'b0; cpu_val = 1'b0; cpu_adv = 1'b0;
        flag_cur_q = cfg_dir_in ? f_q.txin : f_q.rxout;
        if (is_ctrl) begin
            fill_setup = usb_setup && !full_q[0];
            fill_out   = usb_out_stored && !usb_setup && !full_q[0];
            fill       = fill_setup || fill_out;
            ctl_sent   = usb_in_sent && full_q[0] && !f_q.stp && !f_q.rxout;
            ack_s      = cpu_ack_stp && f_q.stp;
            ack_r      = cpu_ack_rxout && f_q.rxout;
            load       = cpu_ack_txin && f_q.txin && !fill;
            usb_op     = fill || ctl_sent;
            usb_val    = fill;
            cpu_op     = ack_s || ack_r || load;
            cpu_val    = load;
        end else begin
            if (cfg_dir_in) begin
                usb_op  = usb_in_sent && full_q[uptr_q];
                usb_val = 1'b0;
                ack_cur = cpu_ack_txin;
            end else begin
                usb_op  = usb_out_stored && !full_q[uptr_q];
                usb_val = 1'b1;
                ack_cur = cpu_ack_rxout;
            end
            usb_adv = usb_op;
            accept  = cpu_release && f_q.own && !flag_cur_q;
            refuse  = cpu_release && f_q.own && flag_cur_q;
            cpu_op  = accept;
            cpu_val = cfg_dir_in;
            cpu_adv = accept;
        end
    end

    ep_bank_ring #(.MAX_BANKS(MAX_BANKS)) u_ring (
        .clk       (clk),
        .rst       (rst),
        .nbanks    (nb_eff),
        .usb_op    (usb_op),
        .usb_val   (usb_val),
        .usb_adv   (usb_adv),
        .cpu_op    (cpu_op),
        .cpu_val   (cpu_val),
        .cpu_adv   (cpu_adv),
        .full_q    (full_q),
        .usb_ptr_q (uptr_q),
        .cpu_ptr_q (cptr_q),
        .full_d    (full_d),
        .cpu_ptr_d (cptr_d)
    );

    // next-state of flags
    always_comb begin
        logic own_nx, flag_nx;
        f_d     = f_q;
        own_nx  = full_d[cptr_d] ^ cfg_dir_in;
        flag_nx = flag_cur_q;
        if (is_ctrl) begin
            f_d.own = 1'b0;
            if (fill_setup)  f_d.stp = 1'b1;
            else if (ack_s)  f_d.stp = 1'b0;
            if (fill_out)    f_d.rxout = 1'b1;
            else if (ack_r)  f_d.rxout = 1'b0;
            if (fill || load)                    f_d.txin = 1'b0;
            else if (ack_s || ack_r || ctl_sent) f_d.txin = 1'b1;
        end else begin
            if (accept)                 flag_nx = own_nx;
            else if (own_nx && !f_q.own) flag_nx = 1'b1;
            else if (ack_cur)           flag_nx = 1'b0;
            f_d.own   = own_nx;
            f_d.txin  = cfg_dir_in ? flag_nx : 1'b0;
            f_d.rxout = cfg_dir_in ? 1'b0 : flag_nx;
            if (refuse) f_d.seq_err = 1'b1;
            if (is_iso && usb_underflow) f_d.stp = 1'b1;
            else if (!is_iso || cpu_ack_stp) f_d.stp = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            f_q.stp     <= 1'b0;
            f_q.rxout   <= 1'b0;
            f_q.txin    <= is_ctrl || cfg_dir_in;
            f_q.own     <= !is_ctrl && cfg_dir_in;
            f_q.seq_err <= 1'b0;
        end else begin
            f_q <= f_d;
        end
    end

    assign st_stp     = f_q.stp;
    assign st_rxout   = f_q.rxout;
    assign st_txin    = f_q.txin;
    assign st_own     = f_q.own;
    assign st_seq_err = f_q.seq_err;
    assign usb_bank   = uptr_q;
    assign cpu_bank   = cptr_q;

    always_comb begin
        if (is_ctrl)         usb_send_req = full_q[0] && !f_q.stp && !f_q.rxout;
        else if (cfg_dir_in) usb_send_req = full_q[uptr_q];
        else                 usb_send_req = 1'b0;
    end

    ep_irq_mask #(.NSRC(3)) u_irq (
        .flags   ({f_q.txin, f_q.rxout, f_q.stp}),
        .enables ({en_txin, en_rxout, en_stp}),
        .irq     (ep_irq)
    );

    AST_SEQ_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
        st_seq_err |=> st_seq_err) else $error("sequence error lost"); // R9
    AST_REFUSED_RELEASE: assert property (@(posedge clk) disable iff (rst)
        (!is_ctrl && cpu_release && st_own && (cfg_dir_in ? st_txin : st_rxout))
        |=> (cpu_bank == $past(cpu_bank) && st_seq_err)) else $error("release not refused"); // R9
    AST_OUT_FLAG_WITH_OWN: assert property (@(posedge clk) disable iff (rst)
        (!is_ctrl && !cfg_dir_in && $rose(st_own)) |-> st_rxout) else $error("own rose without flag"); // R5
    AST_ACK_KEEPS_BANK: assert property (@(posedge clk) disable iff (rst)
        (!is_ctrl && !cpu_release && (cfg_dir_in ? !usb_in_sent : !usb_out_stored)
         && (cpu_ack_rxout || cpu_ack_txin))
        |=> (cpu_bank == $past(cpu_bank) && usb_bank == $past(usb_bank))) else $error("ack moved a bank"); // R6
    AST_CTRL_NO_OWN: assert property (@(posedge clk) disable iff (rst)
        is_ctrl |-> !st_own) else $error("own on control"); // R11
    AST_IN_NO_RXOUT: assert property (@(posedge clk) disable iff (rst)
        (!is_ctrl && cfg_dir_in) |-> !st_rxout) else $error("rxout on IN"); // R11
    AST_OUT_NO_TXIN: assert property (@(posedge clk) disable iff (rst)
        (!is_ctrl && !cfg_dir_in) |-> !st_txin) else $error("txin on OUT"); // R11
    AST_BULK_NO_UNF: assert property (@(posedge clk) disable iff (rst)
        (kind == EP_BULK || kind == EP_INTR) |-> !st_stp) else $error("stp on bulk/intr"); // R10

endmodule

// File: tb/ep_bank_ctrl_test.sv
module ep_bank_ctrl_test;

    localparam int CLK_PERIOD = 10;
    localparam int MAXB = 3;

    localparam logic [7:0] S_SETUP = 8'h01;
    localparam logic [7:0] S_OUT   = 8'h02;
    localparam logic [7:0] S_SENT  = 8'h04;
    localparam logic [7:0] S_UNF   = 8'h08;
    localparam logic [7:0] S_ASTP  = 8'h10;
    localparam logic [7:0] S_ARX   = 8'h20;
    localparam logic [7:0] S_ATX   = 8'h40;
    localparam logic [7:0] S_REL   = 8'h80;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] cfg_type = 2'd0;
    logic cfg_dir_in = 1'b0;
    logic [1:0] cfg_banks = 2'd1;
    logic [7:0] stim = 8'h00;
    logic [2:0] en = 3'b000;
    logic st_stp, st_rxout, st_txin, st_own, st_seq_err, usb_send_req, ep_irq;
    logic [1:0] usb_bank, cpu_bank;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ep_bank_ctrl #(.MAX_BANKS(MAXB)) uut (
        .clk(clk), .rst(rst), .cfg_type(cfg_type), .cfg_dir_in(cfg_dir_in), .cfg_banks(cfg_banks),
        .usb_setup(stim[0]), .usb_out_stored(stim[1]), .usb_in_sent(stim[2]), .usb_underflow(stim[3]),
        .cpu_ack_stp(stim[4]), .cpu_ack_rxout(stim[5]), .cpu_ack_txin(stim[6]), .cpu_release(stim[7]),
        .en_stp(en[0]), .en_rxout(en[1]), .en_txin(en[2]),
        .st_stp(st_stp), .st_rxout(st_rxout), .st_txin(st_txin), .st_own(st_own),
        .st_seq_err(st_seq_err), .usb_bank(usb_bank), .cpu_bank(cpu_bank),
        .usb_send_req(usb_send_req), .ep_irq(ep_irq)
    );

    task automatic chk(input string tag, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic pulse(input logic [7:0] v);
        @(negedge clk) stim = v;
        @(negedge clk) stim = 8'h00;
    endtask

    task automatic restart(input int t, input int d, input int nb);
        @(negedge clk);
        rst = 1'b1; stim = 8'h00; en = 3'b000;
        cfg_type = 2'(t); cfg_dir_in = 1'(d); cfg_banks = 2'(nb);
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_out(input int t, input int nb);
        int nbe = (nb == 0) ? 1 : nb;
        restart(t, 0, nb);
        @(negedge clk);
        chk("R1 out own", int'(st_own), 0);
        chk("R1 out rxout", int'(st_rxout), 0);
        chk("R1 out seq_err", int'(st_seq_err), 0);
        for (int i = 0; i < nbe; i++) begin
            pulse(S_OUT);
            chk("R5 usb_bank advance", int'(usb_bank), (i + 1) % nbe);
            chk("R5 rxout set", int'(st_rxout), 1);
            chk("R5 own set", int'(st_own), 1);
            chk("R11 txin zero on OUT", int'(st_txin), 0);
        end
        pulse(S_OUT);
        chk("R5 drop when full", int'(usb_bank), 0);
        for (int k = 0; k < nbe; k++) begin
            pulse(S_REL);
            chk("R9 refused release bank", int'(cpu_bank), k);
            chk("R9 seq_err set", int'(st_seq_err), 1);
            chk("R9 own kept", int'(st_own), 1);
            pulse(S_ARX);
            chk("R6 ack clears rxout", int'(st_rxout), 0);
            chk("R6 ack keeps own", int'(st_own), 1);
            chk("R6 ack keeps cpu_bank", int'(cpu_bank), k);
            pulse(S_REL);
            chk("R7 cpu_bank advance", int'(cpu_bank), (k + 1) % nbe);
            chk("R7 rxout reload", int'(st_rxout), (k + 1 < nbe) ? 1 : 0);
            chk("R7 own reload", int'(st_own), (k + 1 < nbe) ? 1 : 0);
        end
        chk("R9 seq_err sticky", int'(st_seq_err), 1);
        pulse(S_UNF);
        chk("R10 underflow flag", int'(st_stp), (t == 1) ? 1 : 0);
        pulse(S_ASTP);
        chk("R10 underflow clear", int'(st_stp), 0);
    endtask

    task automatic run_in(input int t, input int nb);
        int nbe = (nb == 0) ? 1 : nb;
        restart(t, 1, nb);
        @(negedge clk);
        chk("R1 in txin", int'(st_txin), 1);
        chk("R1 in own", int'(st_own), 1);
        chk("R1 in send_req", int'(usb_send_req), 0);
        chk("R1 in cpu_bank", int'(cpu_bank), 0);
        for (int k = 0; k < nbe; k++) begin
            pulse(S_ATX);
            chk("R6 ack clears txin", int'(st_txin), 0);
            chk("R6 ack keeps own", int'(st_own), 1);
            chk("R6 ack keeps cpu_bank", int'(cpu_bank), k);
            pulse(S_REL);
            chk("R7 in cpu_bank advance", int'(cpu_bank), (k + 1) % nbe);
            chk("R7 in txin reload", int'(st_txin), (k + 1 < nbe) ? 1 : 0);
            chk("R7 in own reload", int'(st_own), (k + 1 < nbe) ? 1 : 0);
            chk("R8 send_req up", int'(usb_send_req), 1);
            chk("R11 rxout zero on IN", int'(st_rxout), 0);
            chk("R9 no seq_err", int'(st_seq_err), 0);
        end
        for (int j = 0; j < nbe; j++) begin
            pulse(S_SENT);
            chk("R8 usb_bank advance", int'(usb_bank), (j + 1) % nbe);
            chk("R8 txin after free", int'(st_txin), 1);
            chk("R8 own after free", int'(st_own), 1);
            chk("R8 send_req", int'(usb_send_req), (j + 1 < nbe) ? 1 : 0);
        end
        pulse(S_SENT);
        chk("R8 sent ignored when empty", int'(usb_bank), 0);
        for (int e = 0; e < 8; e++) begin
            en = 3'(e);
            #1;
            chk("R12 irq mask", int'(ep_irq), (e >> 2) & 1);
        end
        en = 3'b000;
        pulse(S_UNF);
        chk("R10 in underflow flag", int'(st_stp), (t == 1) ? 1 : 0);
        en = 3'b001;
        #1;
        chk("R12 irq from stp", int'(ep_irq), (t == 1) ? 1 : 0);
        en = 3'b000;
        pulse(S_ASTP);
        chk("R10 in underflow clear", int'(st_stp), 0);
    endtask

    task automatic run_ctrl();
        restart(0, 0, 3);
        @(negedge clk);
        chk("R1 ctrl txin", int'(st_txin), 1);
        chk("R1 ctrl stp", int'(st_stp), 0);
        chk("R1 ctrl own", int'(st_own), 0);
        pulse(S_SETUP);
        chk("R2 setup sets stp", int'(st_stp), 1);
        chk("R2 setup clears txin", int'(st_txin), 0);
        en = 3'b001;
        #1;
        chk("R12 irq on setup", int'(ep_irq), 1);
        en = 3'b110;
        #1;
        chk("R12 irq masked", int'(ep_irq), 0);
        en = 3'b000;
        pulse(S_OUT);
        chk("R3 out dropped when full", int'(st_rxout), 0);
        pulse(S_ASTP);
        chk("R2 ack clears stp", int'(st_stp), 0);
        chk("R2 ack frees bank", int'(st_txin), 1);
        pulse(S_OUT);
        chk("R3 out sets rxout", int'(st_rxout), 1);
        chk("R3 out clears txin", int'(st_txin), 0);
        chk("R3 send_req idle", int'(usb_send_req), 0);
        pulse(S_ARX);
        chk("R3 ack clears rxout", int'(st_rxout), 0);
        chk("R3 ack frees bank", int'(st_txin), 1);
        pulse(S_REL);
        chk("R11 release no own", int'(st_own), 0);
        chk("R11 release no seq_err", int'(st_seq_err), 0);
        pulse(S_ATX);
        chk("R4 ack clears txin", int'(st_txin), 0);
        chk("R4 send_req up", int'(usb_send_req), 1);
        pulse(S_SENT);
        chk("R4 sent drops send_req", int'(usb_send_req), 0);
        chk("R4 sent sets txin", int'(st_txin), 1);
        pulse(S_UNF);
        chk("R10 ctrl underflow ignored", int'(st_stp), 0);
        chk("R11 ctrl banks stay 0", int'(usb_bank) + int'(cpu_bank), 0);
    endtask

    initial begin
        for (int t = 1; t < 4; t++)
            for (int nb = 0; nb <= MAXB; nb++) begin
                run_out(t, nb);
                run_in(t, nb);
            end
        run_ctrl();
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

endmodule